// File: doc/BRIEF.md
# General-Purpose Pin Port Register Block

This block is the register front end of a 16-pin general-purpose port. A simple single-cycle register bus reads and writes a small set of registers: a per-pin function-enable word, a data word, a direction word, an input-enable word and a 32-bit pin-mux word. Data can be written as a whole word or changed bit by bit through write-one-to-set and write-one-to-clear aliases. Direction has no whole-word write and changes only through its own set and clear aliases. Every register demands one access width. A wrong width, or an offset that holds no register, returns an error, zero read data and leaves all state untouched.

After a write that can change what the port drives (data, data-set, data-clear or direction-set), the pin outputs are refreshed one clock later: every pin whose input-enable bit is clear takes its data bit and is flagged as driven. Incoming pin levels are forwarded only for pins that are inputs, have input enabled and have their function enabled. The peripheral functions chosen through the mux word live outside this block.

The bus response (read data and error) is combinational in the cycle of the access; writes take effect at the clock edge that ends the access.

Top module: `gpio_regblock`

## Requirements
- R1: After reset all registers (function-enable, data, direction, input-enable, mux) read as zero and `pinOut` and `pinOutValid` are zero.
- R2: The mux register at byte offset 0x1C accepts only 32-bit accesses (`busSize` = 1); every other register accepts only 16-bit accesses (`busSize` = 0). A wrong-width access raises `busError`.
- R3: The registers sit at byte offsets 0x00 function-enable, 0x04 data, 0x08 data-set, 0x0C data-clear, 0x10 direction-set, 0x14 direction-clear, 0x18 input-enable, 0x1C mux. Any other offset (unaligned or at or above 0x20) raises `busError` and has no effect.
- R4: An access that raises `busError` returns zero on `busRdata` and changes no register.
- R5: Writes to 0x00, 0x04 and 0x18 store `busWdata[15:0]`; a write to 0x1C stores all 32 bits. Reads of 16-bit registers return the value zero-extended to 32 bits.
- R6: A write to 0x08 ORs `busWdata[15:0]` into data; a write to 0x0C clears each data bit whose written bit is 1.
- R7: Direction is changed only by 0x10 (OR in written ones) and 0x14 (clear written ones).
- R8: Reads of 0x04, 0x08 and 0x0C all return the current data word; reads of 0x10 and 0x14 both return the current direction word.
- R9: On the clock edge after a successful write to 0x04, 0x08, 0x0C or 0x10, each pin with input-enable 0 takes its data bit on `pinOut` with `pinOutValid` 1; each pin with input-enable 1 keeps its `pinOut` value and gets `pinOutValid` 0.
- R10: A write to 0x14 does not refresh `pinOut` or `pinOutValid`.
- R11: `pinInValid[i]` is 1 exactly when direction bit i is 0, input-enable bit i is 1 and function-enable bit i is 1; `pinInLevel[i]` equals `pinIn[i]` when valid and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 1 | 0 = 16-bit access, 1 = 32-bit access |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero on error or write |
| busError | output | 1 | Access rejected |
| pinIn | input | 16 | Incoming pin levels |
| pinOut | output | 16 | Driven pin values |
| pinOutValid | output | 16 | Pin is being driven by the port |
| pinInLevel | output | 16 | Gated incoming levels |
| pinInValid | output | 16 | Per-pin input gate is open |

## Verification
A corrupted data or direction word shows at once on the next read through any of its three or two aliases, and on the pins one clock after the next refresh-triggering write. A missed or extra refresh strobe shows as `pinOut`/`pinOutValid` moving one cycle early, late, or after a direction-clear; the bench samples the pins both before and after that edge. A wrong decode shows in the same cycle as an unexpected `busError` or a non-zero read on a rejected access, and as the input gate opening on the wrong pins.

// File: rtl/gpio_regblock_pkg.sv
package gpio_regblock_pkg;

  localparam int NUM_REGS = 8;
  localparam int IDX_W    = 3;

  // Register index = byte offset / 4; order fixes the address map.
  typedef enum logic [IDX_W-1:0] {
    IDX_FER    = 3'd0,
    IDX_DATA   = 3'd1,
    IDX_DSET   = 3'd2,
    IDX_DCLR   = 3'd3,
    IDX_DIRSET = 3'd4,
    IDX_DIRCLR = 3'd5,
    IDX_INEN   = 3'd6,
    IDX_MUX    = 3'd7
  } reg_idx_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_FER,
    RD_DATA,
    RD_DIR,
    RD_INEN,
    RD_MUX
  } rd_sel_e;

  localparam logic SIZE_16 = 1'b0;
  localparam logic SIZE_32 = 1'b1;

  typedef struct packed {
    logic    wrFer;
    logic    wrData;
    logic    setData;
    logic    clrData;
    logic    setDir;
    logic    clrDir;
    logic    wrInen;
    logic    wrMux;
    logic    refresh;
    rd_sel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/gpio_regblock_ctrl.sv
module gpio_regblock_ctrl
  import gpio_regblock_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb,
  output logic              busError
);

  localparam logic [ADDR_W-1:0] MUX_OFF = ADDR_W'(int'(IDX_MUX) * 4);
  localparam logic [ADDR_W-1:0] END_OFF = ADDR_W'(NUM_REGS * 4);

  logic     isMux;
  logic     sizeOk;
  logic     offOk;
  logic     accept;
  logic     doWrite;
  logic     doRead;
  logic     trigger;
  logic     refreshPending;
  reg_idx_e regIdx;

  always_comb begin
    isMux   = (busAddr == MUX_OFF);
    // Width check is independent of whether the offset exists.
    sizeOk  = isMux ? (busSize == SIZE_32) : (busSize == SIZE_16);
    offOk   = (busAddr < END_OFF) && (busAddr[1:0] == 2'b00);
    accept  = busValid && sizeOk && offOk;
    busError = busValid && !accept;
    doWrite = accept && busWrite;
    doRead  = accept && !busWrite;
    regIdx  = reg_idx_e'(busAddr[IDX_W+1:2]);
  end

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    trigger      = 1'b0;
    if (doWrite) begin
      unique case (regIdx)
        IDX_FER:    strb.wrFer   = 1'b1;
        IDX_DATA:   begin strb.wrData  = 1'b1; trigger = 1'b1; end
        IDX_DSET:   begin strb.setData = 1'b1; trigger = 1'b1; end
        IDX_DCLR:   begin strb.clrData = 1'b1; trigger = 1'b1; end
        IDX_DIRSET: begin strb.setDir  = 1'b1; trigger = 1'b1; end
        IDX_DIRCLR: strb.clrDir  = 1'b1;
        IDX_INEN:   strb.wrInen  = 1'b1;
        IDX_MUX:    strb.wrMux   = 1'b1;
        default:    ;
      endcase
    end
    if (doRead) begin
      unique case (regIdx)
        IDX_FER:                      strb.rdSel = RD_FER;
        IDX_DATA, IDX_DSET, IDX_DCLR: strb.rdSel = RD_DATA;
        IDX_DIRSET, IDX_DIRCLR:       strb.rdSel = RD_DIR;
        IDX_INEN:                     strb.rdSel = RD_INEN;
        IDX_MUX:                      strb.rdSel = RD_MUX;
        default:                      strb.rdSel = RD_NONE;
      endcase
    end
    strb.refresh = refreshPending;
  end

  // Pin refresh runs one edge after the register update that caused it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refreshPending <= 1'b0;
    else       refreshPending <= trigger;
  end

endmodule

// File: rtl/gpio_regblock_dp.sv
module gpio_regblock_dp
  import gpio_regblock_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int MUX_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOutValid,
  output logic [PIN_W-1:0]  pinInLevel,
  output logic [PIN_W-1:0]  pinInValid,
  output logic [PIN_W-1:0]  ferQ,
  output logic [PIN_W-1:0]  dataQ,
  output logic [PIN_W-1:0]  dirQ,
  output logic [PIN_W-1:0]  inenQ,
  output logic [MUX_W-1:0]  muxQ
);

  logic [PIN_W-1:0] wLow;
  assign wLow = busWdata[PIN_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ferQ  <= '0;
      dataQ <= '0;
      dirQ  <= '0;
      inenQ <= '0;
      muxQ  <= '0;
    end else begin
      if (strb.wrFer)   ferQ  <= wLow;
      if (strb.wrInen)  inenQ <= wLow;
      if (strb.wrMux)   muxQ  <= busWdata[MUX_W-1:0];
      if (strb.wrData)  dataQ <= wLow;
      if (strb.setData) dataQ <= dataQ | wLow;
      if (strb.clrData) dataQ <= dataQ & ~wLow;
      if (strb.setDir)  dirQ  <= dirQ | wLow;
      if (strb.clrDir)  dirQ  <= dirQ & ~wLow;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_FER:  busRdata = DATA_W'(ferQ);
      RD_DATA: busRdata = DATA_W'(dataQ);
      RD_DIR:  busRdata = DATA_W'(dirQ);
      RD_INEN: busRdata = DATA_W'(inenQ);
      RD_MUX:  busRdata = DATA_W'(muxQ);
      default: busRdata = '0;
    endcase
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    logic outBit;
    logic drvBit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outBit <= 1'b0;
        drvBit <= 1'b0;
      end else if (strb.refresh) begin
        if (!inenQ[i]) begin
          outBit <= dataQ[i];
          drvBit <= 1'b1;
        end else begin
          drvBit <= 1'b0;
        end
      end
    end

    assign pinOut[i]      = outBit;
    assign pinOutValid[i] = drvBit;
    assign pinInValid[i]  = !dirQ[i] && inenQ[i] && ferQ[i];
    assign pinInLevel[i]  = pinInValid[i] && pinIn[i];
  end

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_regblock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PIN_W  = 16,
  parameter int MUX_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busError,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOutValid,
  output logic [PIN_W-1:0]  pinInLevel,
  output logic [PIN_W-1:0]  pinInValid
);

  strobes_t         strb;
  logic [PIN_W-1:0] ferQ;
  logic [PIN_W-1:0] dataQ;
  logic [PIN_W-1:0] dirQ;
  logic [PIN_W-1:0] inenQ;
  logic [MUX_W-1:0] muxQ;

  gpio_regblock_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busSize  (busSize),
    .busAddr  (busAddr),
    .strb     (strb),
    .busError (busError)
  );

  gpio_regblock_dp #(.PIN_W(PIN_W), .MUX_W(MUX_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .pinIn       (pinIn),
    .pinOut      (pinOut),
    .pinOutValid (pinOutValid),
    .pinInLevel  (pinInLevel),
    .pinInValid  (pinInValid),
    .ferQ        (ferQ),
    .dataQ       (dataQ),
    .dirQ        (dirQ),
    .inenQ       (inenQ),
    .muxQ        (muxQ)
  );

endmodule

// File: rtl/gpio_regblock_chk.sv
module gpio_regblock_chk #(
  parameter int ADDR_W = 8,
  parameter int PIN_W  = 16,
  parameter int MUX_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic              busSize,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busError,
  input logic [PIN_W-1:0]  pinOut,
  input logic [PIN_W-1:0]  pinOutValid,
  input logic [PIN_W-1:0]  pinInLevel,
  input logic [PIN_W-1:0]  pinInValid,
  input logic [PIN_W-1:0]  ferQ,
  input logic [PIN_W-1:0]  dataQ,
  input logic [PIN_W-1:0]  dirQ,
  input logic [PIN_W-1:0]  inenQ,
  input logic [MUX_W-1:0]  muxQ
);

  logic goodWr;
  assign goodWr = busValid && busWrite && !busError;

  // R2
  mux_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr == ADDR_W'(28) && !busSize) |-> busError);

  // R4
  err_rdata_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busError) |-> (busRdata == '0));

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busError) |=> ($stable(dataQ) && $stable(dirQ) && $stable(ferQ)
                                && $stable(inenQ) && $stable(muxQ)));

  // R6
  data_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && busAddr == ADDR_W'(8)) |=>
      (dataQ == ($past(dataQ) | $past(busWdata[PIN_W-1:0]))));

  // R6
  data_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && busAddr == ADDR_W'(12)) |=>
      (dataQ == ($past(dataQ) & ~$past(busWdata[PIN_W-1:0]))));

  // R7
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && busAddr == ADDR_W'(20)) |=>
      (dirQ == ($past(dirQ) & ~$past(busWdata[PIN_W-1:0]))));

  // R10
  dirclr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && busAddr == ADDR_W'(20)) |=> ##1 ($stable(pinOut) && $stable(pinOutValid)));

  // R11
  gate_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pinInValid & dirQ) == '0) && ((pinInLevel & ~pinInValid) == '0));

endmodule

bind gpio_regblock gpio_regblock_chk #(
  .ADDR_W(ADDR_W), .PIN_W(PIN_W), .MUX_W(MUX_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/gpio_regblock_tb.sv
module gpio_regblock_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic        busSize = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busError;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;
  logic [15:0] pinOutValid;
  logic [15:0] pinInLevel;
  logic [15:0] pinInValid;

  int checks = 0;
  int failures = 0;

  // Bench model of register state.
  logic [15:0] mFer = '0, mData = '0, mDir = '0, mInen = '0;
  logic [31:0] mMux = '0;
  logic [15:0] mPin = '0, mPinV = '0;

  always #5 clk = ~clk;

  gpio_regblock u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busError(busError), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutValid(pinOutValid),
    .pinInLevel(pinInLevel), .pinInValid(pinInValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic [7:0] addr, input logic sz,
                       input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busSize = sz; busWdata = wd;
    #2;
    rd = busRdata; er = busError;
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  function automatic void modelRefresh();
    mPin  = (mData & ~mInen) | (mPin & mInen);
    mPinV = ~mInen;
  endfunction

  // Successful write with model update.
  task automatic wr(input string tag, input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] rd; logic er;
    busOp(1'b1, addr, (addr == 8'h1C), wd, rd, er);
    check({tag, " write accepted"}, {31'd0, er}, 32'd0);
    case (addr)
      8'h00: mFer = wd[15:0];
      8'h04: mData = wd[15:0];
      8'h08: mData = mData | wd[15:0];
      8'h0C: mData = mData & ~wd[15:0];
      8'h10: mDir = mDir | wd[15:0];
      8'h14: mDir = mDir & ~wd[15:0];
      8'h18: mInen = wd[15:0];
      8'h1C: mMux = wd;
      default: ;
    endcase
    if (addr inside {8'h04, 8'h08, 8'h0C, 8'h10}) modelRefresh();
  endtask

  task automatic rdChk(input string tag, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    busOp(1'b0, addr, (addr == 8'h1C), '0, rd, er);
    check({tag, " read ok"}, {31'd0, er}, 32'd0);
    check(tag, rd, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic test_reset();
    check("R1 pinOut", {16'd0, pinOut}, 32'd0);
    check("R1 pinOutValid", {16'd0, pinOutValid}, 32'd0);
    rdChk("R1 fer", 8'h00, 32'd0);
    rdChk("R1 data", 8'h04, 32'd0);
    rdChk("R1 dir", 8'h10, 32'd0);
    rdChk("R1 inen", 8'h18, 32'd0);
    rdChk("R1 mux", 8'h1C, 32'd0);
  endtask

  task automatic test_plain();
    wr("R5 fer", 8'h00, 32'hFFFF_A5C3);
    rdChk("R5 fer readback", 8'h00, 32'h0000_A5C3);
    wr("R5 mux", 8'h1C, 32'hDEAD_BEEF);
    rdChk("R5 mux readback", 8'h1C, 32'hDEAD_BEEF);
    wr("R5 inen", 8'h18, 32'h0000_00F0);
    rdChk("R5 inen readback", 8'h18, 32'h0000_00F0);
    wr("R5 data", 8'h04, 32'h5555_1234);
    rdChk("R5 data readback", 8'h04, 32'h0000_1234);
    idle(1);
  endtask

  task automatic test_refresh();
    logic [15:0] oldPin, oldV;
    oldPin = pinOut; oldV = pinOutValid;
    check("R9 prior pinOut", {16'd0, pinOut}, {16'd0, mPin});
    wr("R9 data", 8'h04, 32'h0000_3C3C);
    // Register committed, pins not yet refreshed.
    check("R9 pinOut before refresh edge", {16'd0, pinOut}, {16'd0, oldPin});
    check("R9 valid before refresh edge", {16'd0, pinOutValid}, {16'd0, oldV});
    idle(1);
    check("R9 pinOut after refresh", {16'd0, pinOut}, {16'd0, mPin});
    check("R9 valid after refresh", {16'd0, pinOutValid}, 32'h0000_FF0F);
  endtask

  task automatic test_data_alias();
    wr("R6 base", 8'h04, 32'h0000_00F0);
    wr("R6 set", 8'h08, 32'h0000_0F01);
    rdChk("R8 data via set alias", 8'h08, 32'h0000_0FF1);
    wr("R6 clear", 8'h0C, 32'h0000_00F0);
    rdChk("R8 data via clear alias", 8'h0C, 32'h0000_0F01);
    rdChk("R6 data after clear", 8'h04, 32'h0000_0F01);
    idle(1);
    check("R9 pins after clear alias", {16'd0, pinOut}, {16'd0, mPin});
  endtask

  task automatic test_dir();
    logic [15:0] keepV, keepP;
    wr("R7 dir set", 8'h10, 32'h0000_8001);
    rdChk("R8 dir via clear alias", 8'h14, 32'h0000_8001);
    wr("R7 dir clear", 8'h14, 32'h0000_0001);
    rdChk("R8 dir via set alias", 8'h10, 32'h0000_8000);
    idle(1);
    wr("R10 inen change", 8'h18, 32'h0000_0000);
    keepV = pinOutValid; keepP = pinOut;
    wr("R10 dir clear", 8'h14, 32'h0000_0000);
    idle(2);
    check("R10 valid unchanged", {16'd0, pinOutValid}, {16'd0, keepV});
    check("R10 pinOut unchanged", {16'd0, pinOut}, {16'd0, keepP});
    wr("R9 dir set refresh", 8'h10, 32'h0000_0000);
    idle(1);
    check("R9 valid after dir set", {16'd0, pinOutValid}, 32'h0000_FFFF);
    check("R9 pins after dir set", {16'd0, pinOut}, {16'd0, mData});
  endtask

  task automatic test_size();
    logic [31:0] rd; logic er;
    busOp(1'b1, 8'h1C, 1'b0, 32'h1111_2222, rd, er);
    check("R2 mux 16-bit write err", {31'd0, er}, 32'd1);
    rdChk("R4 mux unchanged", 8'h1C, mMux);
    busOp(1'b1, 8'h04, 1'b1, 32'h0000_FFFF, rd, er);
    check("R2 data 32-bit write err", {31'd0, er}, 32'd1);
    rdChk("R4 data unchanged", 8'h04, {16'd0, mData});
    busOp(1'b0, 8'h10, 1'b1, '0, rd, er);
    check("R2 dir 32-bit read err", {31'd0, er}, 32'd1);
    check("R4 err rdata zero", rd, 32'd0);
    busOp(1'b0, 8'h1C, 1'b0, '0, rd, er);
    check("R2 mux 16-bit read err", {31'd0, er}, 32'd1);
    check("R4 mux err rdata zero", rd, 32'd0);
  endtask

  task automatic test_invalid();
    logic [31:0] rd; logic er;
    busOp(1'b1, 8'h20, 1'b0, 32'h0000_FFFF, rd, er);
    check("R3 offset 0x20 err", {31'd0, er}, 32'd1);
    busOp(1'b1, 8'h06, 1'b0, 32'h0000_FFFF, rd, er);
    check("R3 unaligned err", {31'd0, er}, 32'd1);
    busOp(1'b0, 8'h40, 1'b0, '0, rd, er);
    check("R3 offset 0x40 read err", {31'd0, er}, 32'd1);
    check("R4 invalid rdata zero", rd, 32'd0);
    rdChk("R3 data unchanged", 8'h04, {16'd0, mData});
    rdChk("R3 fer unchanged", 8'h00, {16'd0, mFer});
    rdChk("R3 inen unchanged", 8'h18, {16'd0, mInen});
  endtask

  task automatic test_input();
    wr("R11 fer", 8'h00, 32'h0000_00FF);
    wr("R11 inen", 8'h18, 32'h0000_0F0F);
    wr("R11 dir", 8'h10, 32'h0000_0003);
    pinIn = 16'hFFFF;
    #1;
    check("R11 gate", {16'd0, pinInValid}, 32'h0000_000C);
    check("R11 level all high", {16'd0, pinInLevel}, 32'h0000_000C);
    pinIn = 16'h0004;
    #1;
    check("R11 level one high", {16'd0, pinInLevel}, 32'h0000_0004);
    wr("R11 dir clear", 8'h14, 32'h0000_0003);
    check("R11 gate after dir clear", {16'd0, pinInValid}, 32'h0000_000F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    idle(1);
    test_reset();
    test_plain();
    test_refresh();
    test_data_alias();
    test_dir();
    test_size();
    test_invalid();
    test_input();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule